// File: doc/BRIEF.md
# Xon/Xoff Software Flow Control Engine

This block sits between a UART receiver and its receive FIFO and drives character-level flow control in both directions. Each character the receiver assembles is checked against four programmable control characters: two "resume" codes and two "pause" codes. A pause match holds off the local transmitter and a resume match lets it run again. The serializer samples `tx_allow` only at a character boundary, so a character already on the wire always finishes. Flow-control characters are consumed and never reach the FIFO. A matching mode can be chosen: no matching, single-character matching, or matching on two consecutive characters. A fourth mode does not act on flow control. It only marks a special character, which is still stored.

In the other direction, the block watches the receive FIFO fill level against a trigger. When the fill goes above the trigger, it asks the serializer to send the pause code or codes. When the fill falls back below the trigger, it asks for the resume code or codes. An injected character is held on `inj_req`/`inj_data` until the serializer accepts it with `tx_take`. The serializer gives such a request priority over FIFO data at the next character boundary.

The serializer and the FIFO storage are outside this block.

Top module: `swfc_engine`

## Requirements
- R1: After reset, `tx_allow` is 1, `fc_flag` is 0, `fifo_wr` is 0 and `inj_req` is 0, and all four control-character registers hold zero.
- R2: A write with `reg_we`=1 loads `reg_wdata` into the register picked by `reg_sel`: 0 = resume-1, 1 = resume-2, 2 = pause-1, 3 = pause-2.
- R3: `cfg_mode` selects the matching behaviour: 0 = off, 1 = single, 2 = pair, 3 = special. In off mode, every received character is written to the FIFO one cycle after `rx_valid`, and `tx_allow` is 1.
- R4: In single mode, a character equal to pause-1 drives `tx_allow` to 0 and `fc_flag` to 1 from the next cycle. A character equal to resume-1 drives `tx_allow` to 1 and `fc_flag` to 0. A matched character is not written to the FIFO. If pause-1 equals resume-1, the pause match wins.
- R5: In pair mode, pause-1 followed by pause-2 holds the transmitter off, and resume-1 followed by resume-2 releases it. Neither character of a matched pair is written to the FIFO.
- R6: In pair mode, if the character after a pending first code does not complete the pair, the pending character is written first. The new character is written in the following cycle, unless it is itself a first code, in which case it becomes the new pending character.
- R7: `cfg_wlen` (0..3 = 5..8 bits) limits every comparison to the low bits of the character, with bit 0 as the first bit received. The value written to the FIFO is the full 8-bit received value.
- R8: In special mode, each character is compared with pause-2 only. Every character is written to the FIFO, a match sets `fc_flag`, and `tx_allow` stays 1.
- R9: `fc_flag` is 1 while the transmitter is held off or while the special-match flag is set. A one-cycle `flag_clr` pulse clears the special-match flag.
- R10: With `cfg_auto_send`=1 in single or pair mode, a fill above the trigger raises `inj_req` with pause-1, and then pause-2 in pair mode. Each character is held stable until `tx_take`. The pause sequence is sent only once per crossing.
- R11: After a pause sequence has been sent, a fill below the trigger sends resume-1, and then resume-2 in pair mode. A fill equal to the trigger starts nothing.
- R12: `rx_valid` is a one-cycle pulse, and at least one idle cycle separates two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Matching mode (off, single, pair, special) |
| cfg_wlen | input | 2 | Character length code, 5 to 8 bits |
| cfg_auto_send | input | 1 | Enables automatic pause/resume injection |
| reg_we | input | 1 | Control-character register write strobe |
| reg_sel | input | 2 | Control-character register select |
| reg_wdata | input | 8 | Control-character write value |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| fifo_wr | output | 1 | Receive FIFO write enable |
| fifo_wdata | output | 8 | Receive FIFO write data |
| rx_fill | input | FILL_W | Current receive FIFO fill level |
| rx_trigger | input | FILL_W | Receive trigger level |
| tx_allow | output | 1 | Local transmitter may start a new data character |
| tx_take | input | 1 | Serializer accepted the injected character |
| inj_req | output | 1 | Injected character request |
| inj_data | output | 8 | Injected character |
| flag_clr | input | 1 | Clears the special-match flag |
| fc_flag | output | 1 | Flow-control / special-match status |

## Verification
The bench checks the reset values of the control registers by receiving a zero byte in single mode. A design that did not clear those registers would store that byte instead of pausing. It breaks pairs on purpose: a pause-1 followed by a plain byte, and a pause-1 followed by resume-1. A design with the wrong flush order, a lost second character, or a missed restart of the pair would leave the scoreboard with a reordered or missing byte. It sends characters whose high bits differ from the programmed codes at the 5-bit length, where a full-width comparison would wrongly store them. It also holds the fill exactly at the trigger, where a design that compared with the wrong relational operator would send a spurious resume code.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int CHAR_W = 8;
  localparam int NUM_CTL = 4;

  localparam logic [1:0] SEL_ON1  = 2'd0;
  localparam logic [1:0] SEL_ON2  = 2'd1;
  localparam logic [1:0] SEL_OFF1 = 2'd2;
  localparam logic [1:0] SEL_OFF2 = 2'd3;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_SINGLE  = 2'd1,
    MODE_PAIR    = 2'd2,
    MODE_SPECIAL = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    INJ_IDLE   = 2'd0,
    INJ_FIRST  = 2'd1,
    INJ_SECOND = 2'd2
  } inj_st_e;

  // mask of the low 5..8 bits selected by the word-length code
  function automatic logic [CHAR_W-1:0] wlen_mask(input logic [1:0] wlen);
    return {CHAR_W{1'b1}} >> (2'd3 - wlen);
  endfunction

  function automatic logic char_eq(input logic [CHAR_W-1:0] a,
                                   input logic [CHAR_W-1:0] b,
                                   input logic [1:0] wlen);
    return ((a ^ b) & wlen_mask(wlen)) == '0;
  endfunction

  function automatic logic flow_mode(input mode_e m);
    return (m == MODE_SINGLE) || (m == MODE_PAIR);
  endfunction
endpackage

// File: rtl/swfc_regs.sv
module swfc_regs
  import swfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [CHAR_W-1:0] wdata,
  output logic [CHAR_W-1:0] on1,
  output logic [CHAR_W-1:0] on2,
  output logic [CHAR_W-1:0] off1,
  output logic [CHAR_W-1:0] off2
);
  for (genvar i = 0; i < NUM_CTL; i++) begin : g_bank
    logic [CHAR_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              q <= '0;
      else if (we && (sel == 2'(i)))           q <= wdata;
    end
  end

  assign on1  = g_bank[0].q;
  assign on2  = g_bank[1].q;
  assign off1 = g_bank[2].q;
  assign off2 = g_bank[3].q;

  // R2
  off1_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_OFF1) |=> (off1 == $past(wdata)));
  // R2
  on2_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_ON2) |=> (on2 == $past(wdata)));
endmodule

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic [1:0]        wlen,
  input  logic [CHAR_W-1:0] on1,
  input  logic [CHAR_W-1:0] on2,
  input  logic [CHAR_W-1:0] off1,
  input  logic [CHAR_W-1:0] off2,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              flag_clr,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wdata,
  output logic              tx_allow,
  output logic              fc_flag
);
  logic hit_on1, hit_on2, hit_off1, hit_off2;
  assign hit_on1  = char_eq(rx_data, on1,  wlen);
  assign hit_on2  = char_eq(rx_data, on2,  wlen);
  assign hit_off1 = char_eq(rx_data, off1, wlen);
  assign hit_off2 = char_eq(rx_data, off2, wlen);

  logic              pend_v, pend_off, spill_v, held, spc_q;
  logic [CHAR_W-1:0] pend_d, spill_d;

  // named events for the checks
  logic xoff_evt, xon_evt, spc_evt, flush_evt, pend_set, spill_set;
  logic wr_now;
  logic [CHAR_W-1:0] wr_data;
  logic drop_evt;

  always_comb begin
    xoff_evt  = 1'b0;
    xon_evt   = 1'b0;
    spc_evt   = 1'b0;
    flush_evt = 1'b0;
    pend_set  = 1'b0;
    spill_set = 1'b0;
    wr_now    = 1'b0;
    wr_data   = rx_data;
    if (rx_valid) begin
      unique case (mode)
        MODE_OFF: wr_now = 1'b1;
        MODE_SINGLE: begin
          if (hit_off1)     xoff_evt = 1'b1;
          else if (hit_on1) xon_evt  = 1'b1;
          else              wr_now   = 1'b1;
        end
        MODE_PAIR: begin
          if (pend_v) begin
            if (pend_off && hit_off2)       xoff_evt = 1'b1;
            else if (!pend_off && hit_on2)  xon_evt  = 1'b1;
            else begin
              flush_evt = 1'b1;
              wr_now    = 1'b1;
              wr_data   = pend_d;
              if (hit_off1 || hit_on1) pend_set  = 1'b1;
              else                     spill_set = 1'b1;
            end
          end else if (hit_off1 || hit_on1) begin
            pend_set = 1'b1;
          end else begin
            wr_now = 1'b1;
          end
        end
        MODE_SPECIAL: begin
          wr_now  = 1'b1;
          spc_evt = hit_off2;
        end
        default: wr_now = 1'b1;
      endcase
    end
  end

  assign drop_evt = xoff_evt || xon_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      pend_v     <= 1'b0;
      pend_off   <= 1'b0;
      pend_d     <= '0;
      spill_v    <= 1'b0;
      spill_d    <= '0;
      held       <= 1'b0;
      spc_q      <= 1'b0;
    end else begin
      fifo_wr <= 1'b0;
      if (wr_now) begin
        fifo_wr    <= 1'b1;
        fifo_wdata <= wr_data;
      end else if (spill_v) begin
        fifo_wr    <= 1'b1;
        fifo_wdata <= spill_d;
      end

      spill_v <= spill_set;
      if (spill_set) spill_d <= rx_data;

      if (mode != MODE_PAIR) begin
        pend_v <= 1'b0;
      end else if (pend_set) begin
        pend_v   <= 1'b1;
        pend_d   <= rx_data;
        pend_off <= hit_off1;
      end else if (rx_valid) begin
        pend_v <= 1'b0;
      end

      if (!flow_mode(mode)) held <= 1'b0;
      else if (xoff_evt)    held <= 1'b1;
      else if (xon_evt)     held <= 1'b0;

      if (spc_evt)       spc_q <= 1'b1;
      else if (flag_clr) spc_q <= 1'b0;
    end
  end

  assign tx_allow = !held;
  assign fc_flag  = held || spc_q;

  // R12
  rx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R4
  xoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_evt |=> (!tx_allow && fc_flag));
  // R4
  xon_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_evt && !spc_q) |=> tx_allow);
  // R5
  ctl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !fifo_wr);
  // R6
  flush_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_evt && spill_set) |-> ##1 fifo_wr ##1 fifo_wr);
  // R8
  spc_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spc_evt |=> (fifo_wr && fc_flag && tx_allow));
endmodule

// File: rtl/swfc_tx_inject.sv
module swfc_tx_inject
  import swfc_pkg::*;
#(
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic              auto_en,
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] trigger,
  input  logic [CHAR_W-1:0] on1,
  input  logic [CHAR_W-1:0] on2,
  input  logic [CHAR_W-1:0] off1,
  input  logic [CHAR_W-1:0] off2,
  input  logic              tx_take,
  output logic              inj_req,
  output logic [CHAR_W-1:0] inj_data
);
  function automatic logic above_trig(input logic [FILL_W-1:0] f,
                                      input logic [FILL_W-1:0] t);
    return f > t;
  endfunction

  function automatic logic below_trig(input logic [FILL_W-1:0] f,
                                      input logic [FILL_W-1:0] t);
    return f < t;
  endfunction

  inj_st_e st;
  logic    send_off, remote_off;

  logic start_evt, start_off, done_evt;
  assign start_off = !remote_off && above_trig(fill, trigger);
  assign start_evt = (st == INJ_IDLE) && auto_en && flow_mode(mode) &&
                     (start_off || (remote_off && below_trig(fill, trigger)));
  assign done_evt  = tx_take && ((st == INJ_SECOND) ||
                     ((st == INJ_FIRST) && (mode != MODE_PAIR)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= INJ_IDLE;
      send_off   <= 1'b0;
      remote_off <= 1'b0;
      inj_data   <= '0;
    end else begin
      unique case (st)
        INJ_IDLE: if (start_evt) begin
          st         <= INJ_FIRST;
          send_off   <= start_off;
          remote_off <= start_off;
          inj_data   <= start_off ? off1 : on1;
        end
        INJ_FIRST: if (tx_take) begin
          if (mode == MODE_PAIR) begin
            st       <= INJ_SECOND;
            inj_data <= send_off ? off2 : on2;
          end else begin
            st <= INJ_IDLE;
          end
        end
        INJ_SECOND: if (tx_take) st <= INJ_IDLE;
        default: st <= INJ_IDLE;
      endcase
    end
  end

  assign inj_req = (st != INJ_IDLE);

  // R10
  inj_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_req && !tx_take) |=> (inj_req && $stable(inj_data)));
  // R10
  inj_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> inj_req);
  // R11
  inj_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !inj_req);
endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
  import swfc_pkg::*;
#(
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_auto_send,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              fifo_wr,
  output logic [7:0]        fifo_wdata,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] rx_trigger,
  output logic              tx_allow,
  input  logic              tx_take,
  output logic              inj_req,
  output logic [7:0]        inj_data,
  input  logic              flag_clr,
  output logic              fc_flag
);
  mode_e mode;
  assign mode = mode_e'(cfg_mode);

  logic [CHAR_W-1:0] on1, on2, off1, off2;

  swfc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .on1(on1), .on2(on2), .off1(off1), .off2(off2)
  );

  swfc_rx_match u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wlen(cfg_wlen),
    .on1(on1), .on2(on2), .off1(off1), .off2(off2),
    .rx_valid(rx_valid), .rx_data(rx_data), .flag_clr(flag_clr),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .tx_allow(tx_allow), .fc_flag(fc_flag)
  );

  swfc_tx_inject #(.FILL_W(FILL_W)) u_inj (
    .clk(clk), .rst_n(rst_n), .mode(mode), .auto_en(cfg_auto_send),
    .fill(rx_fill), .trigger(rx_trigger),
    .on1(on1), .on2(on2), .off1(off1), .off2(off2),
    .tx_take(tx_take), .inj_req(inj_req), .inj_data(inj_data)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (tx_allow && !fc_flag && !fifo_wr && !inj_req));
endmodule

// File: tb/sim_swfc_engine.sv
module sim_swfc_engine;
  localparam int FW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0, cfg_wlen = 2'd3;
  logic cfg_auto_send = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h0;
  logic fifo_wr, tx_allow, inj_req, fc_flag;
  logic [7:0] fifo_wdata, inj_data;
  logic [FW-1:0] rx_fill = '0, rx_trigger = 6'd8;
  logic tx_take = 1'b0, flag_clr = 1'b0;

  always #5 clk = ~clk;

  swfc_engine #(.FILL_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen),
    .cfg_auto_send(cfg_auto_send), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .rx_fill(rx_fill),
    .rx_trigger(rx_trigger), .tx_allow(tx_allow), .tx_take(tx_take),
    .inj_req(inj_req), .inj_data(inj_data), .flag_clr(flag_clr),
    .fc_flag(fc_flag)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string wr_tag = "R3";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every FIFO write must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      if (exp_q.size() == 0) chk({wr_tag, " unexpected write"}, {24'h0, fifo_wdata}, 32'hFFFF);
      else chk({wr_tag, " fifo data"}, {24'h0, fifo_wdata}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  // drive one character, then leave room for a flush write
  task automatic rx_char(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic take_inj(input string tag, input logic [7:0] exp);
    chk({tag, " inj_req"}, {31'h0, inj_req}, 32'h1);
    chk({tag, " inj_data"}, {24'h0, inj_data}, {24'h0, exp});
    repeat (2) begin
      @(negedge clk);
      chk({tag, " inj hold"}, {24'h0, inj_data}, {24'h0, exp});
    end
    tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx_allow", {31'h0, tx_allow}, 32'h1);
    chk("R1 fc_flag", {31'h0, fc_flag}, 32'h0);
    chk("R1 fifo_wr", {31'h0, fifo_wr}, 32'h0);
    chk("R1 inj_req", {31'h0, inj_req}, 32'h0);
    rst_n = 1'b1;
    // R1 registers reset to zero: a zero byte matches pause-1 in single mode
    cfg_mode = 2'd1;
    wr_tag = "R1";
    rx_char(8'h00);
    chk("R1 zero regs hold", {31'h0, tx_allow}, 32'h0);
    // R2 program the control characters
    wr_reg(2'd0, 8'h11); wr_reg(2'd1, 8'h12);
    wr_reg(2'd2, 8'h13); wr_reg(2'd3, 8'h14);
    // R3 off mode passes everything and releases the hold
    cfg_mode = 2'd0; wr_tag = "R3";
    @(negedge clk);
    chk("R3 off allow", {31'h0, tx_allow}, 32'h1);
    exp_q.push_back(8'h13); rx_char(8'h13);
    exp_q.push_back(8'h11); rx_char(8'h11);
    // R4 single mode
    cfg_mode = 2'd1; wr_tag = "R4";
    exp_q.push_back(8'h41); rx_char(8'h41);
    rx_char(8'h13);
    chk("R4 xoff allow", {31'h0, tx_allow}, 32'h0);
    chk("R4 xoff flag", {31'h0, fc_flag}, 32'h1);
    exp_q.push_back(8'h42); rx_char(8'h42);
    chk("R4 still held", {31'h0, tx_allow}, 32'h0);
    rx_char(8'h11);
    chk("R4 xon allow", {31'h0, tx_allow}, 32'h1);
    chk("R4 xon flag", {31'h0, fc_flag}, 32'h0);
    // R7 five-bit length: high bits ignored in compare, stored full
    cfg_wlen = 2'd0; wr_tag = "R7";
    rx_char(8'hF3);
    chk("R7 masked xoff", {31'h0, tx_allow}, 32'h0);
    rx_char(8'h31);
    chk("R7 masked xon", {31'h0, tx_allow}, 32'h1);
    cfg_wlen = 2'd3;
    exp_q.push_back(8'h93); rx_char(8'h93);
    chk("R7 full width no match", {31'h0, tx_allow}, 32'h1);
    // R5 pair mode
    cfg_mode = 2'd2; wr_tag = "R5";
    rx_char(8'h13);
    chk("R5 first only", {31'h0, tx_allow}, 32'h1);
    rx_char(8'h14);
    chk("R5 pair hold", {31'h0, tx_allow}, 32'h0);
    rx_char(8'h11); rx_char(8'h12);
    chk("R5 pair release", {31'h0, tx_allow}, 32'h1);
    // R6 broken pair: pending then plain byte
    wr_tag = "R6";
    exp_q.push_back(8'h13); exp_q.push_back(8'h55);
    rx_char(8'h13); rx_char(8'h55);
    chk("R6 no hold", {31'h0, tx_allow}, 32'h1);
    // R6 broken pair restarting a new pair
    rx_char(8'h13); rx_char(8'h14);
    exp_q.push_back(8'h13);
    rx_char(8'h13); rx_char(8'h11); rx_char(8'h12);
    chk("R6 restarted pair released", {31'h0, tx_allow}, 32'h1);
    chk("R6 queue drained", exp_q.size(), 0);
    // R8 special mode
    cfg_mode = 2'd3; wr_tag = "R8";
    exp_q.push_back(8'h14); rx_char(8'h14);
    chk("R8 flag", {31'h0, fc_flag}, 32'h1);
    chk("R8 allow", {31'h0, tx_allow}, 32'h1);
    // R9 flag clear
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R9 flag cleared", {31'h0, fc_flag}, 32'h0);
    exp_q.push_back(8'h13); rx_char(8'h13);
    chk("R9 no flag on other code", {31'h0, fc_flag}, 32'h0);
    chk("R8 queue drained", exp_q.size(), 0);
    // R10 single-mode auto send
    cfg_mode = 2'd1; cfg_auto_send = 1'b1;
    rx_fill = 6'd9; @(negedge clk);
    take_inj("R10 single", 8'h13);
    chk("R10 done", {31'h0, inj_req}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R10 no resend", {31'h0, inj_req}, 32'h0);
    // R11 equal then below
    rx_fill = 6'd8; repeat (3) @(negedge clk);
    chk("R11 equal idle", {31'h0, inj_req}, 32'h0);
    rx_fill = 6'd7; @(negedge clk);
    take_inj("R11 single", 8'h11);
    chk("R11 done", {31'h0, inj_req}, 32'h0);
    // R10/R11 pair-mode sequences
    cfg_mode = 2'd2; rx_fill = 6'd20; @(negedge clk);
    take_inj("R10 pair 1", 8'h13);
    take_inj("R10 pair 2", 8'h14);
    chk("R10 pair done", {31'h0, inj_req}, 32'h0);
    rx_fill = 6'd2; @(negedge clk);
    take_inj("R11 pair 1", 8'h11);
    take_inj("R11 pair 2", 8'h12);
    chk("R11 pair done", {31'h0, inj_req}, 32'h0);
    chk("R3 queue empty", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule